// File: doc/BRIEF.md
# SMBus Indexed Block-Access Configuration Target

This block is a target on a two-wire SMBus/I2C segment. It holds the configuration bank of a clock fanout device: one enable bit, one edge-rate bit and one swing bit for each of nine outputs. It also has a fixed identification byte and a programmable length byte. Every register comes out of reset with a working value, so the fanout runs with no bus traffic. A host changes the settings with indexed block transfers.

A write carries a start index, then an explicit byte count, then that many data bytes. These land at consecutive locations. A read first sets the start index with a short write phase. After a repeated START and the read address, the target sends the length byte and then data from consecutive locations until the host answers with NACK. The 7-bit target address is one of three values. A two-bit select input picks the address, and the block captures it once after reset.

SCL and SDA come in raw and pass through two-flop synchronizers. The block pulls SDA low through an open-drain enable output. START and STOP are recognised as SDA edges while SCL is high.

Top module: `smb_cfg_target`

## Requirements
- R1: After reset the bank holds these values. Index 0 = 8'hFF and index 1 = 8'h01 (all nine enables set). Index 2 = 8'h00 and index 3 = 8'h00 (edge-rate bits clear). Index 4 = 8'hFF and index 5 = 8'h01 (swing bits set). Index 6 = 8'h5A. Index 7 = 8'h00. Index 8 = 8'h09.
- R2: The target address is captured in the first clock after reset release. Select 2'b00 gives 7'h68, 2'b01 gives 7'h6A, 2'b10 gives 7'h6C and 2'b11 gives 7'h68. Later changes of the select input have no effect until the next reset.
- R3: An address byte that matches is acknowledged with either direction bit. SDA is held low through the ninth SCL pulse. An address byte that does not match gets no acknowledge, and SDA stays released until the next START or STOP. The registers do not change.
- R4: A block write is address+W, index N, count X, then data. Data byte k goes to location N+k for k < X, and every byte is acknowledged. Output k is driven from bit k%8 of the register at base+k/8, with base 0 for enables, 2 for edge-rate and 4 for swing.
- R5: Data bytes sent after the first X are acknowledged and discarded.
- R6: The index advances after each data byte. From index 8, or from any index above 8, it goes next to 0.
- R7: A read is address+W, index N, repeated START, then address+R. The target then sends the index-8 byte, followed by data from N upward. After the host NACKs a byte, SDA stays released until STOP or START.
- R8: Index 6 is read-only and index 7 and indices 9 and above are unimplemented. Writes to these are acknowledged and discarded. Reads of index 7 and of 9 and above return 8'h00. Reserved bits 7:1 of indices 1, 3 and 5 read 0.
- R9: Index 8 is writable, and a new value is the length byte returned by later reads.
- R10: A STOP at any point returns the engine to idle with SDA released. A data byte cut off by the STOP is not written.
- R11: The target changes SDA only while synchronized SCL is low, except for releasing it at START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level (wired-AND of all drivers) |
| addr_sel | input | 2 | Target address select, captured after reset |
| sda_drive_low | output | 1 | 1 = pull SDA low (open-drain enable) |
| out_en | output | 9 | Per-output enable |
| slew_sel | output | 9 | Per-output edge-rate select |
| amp_sel | output | 9 | Per-output swing select |

## Verification
The hardest states to reach from the ports lie where the index crosses the end of the bank in the middle of a transfer. In these states the engine must write, discard or read back zero depending on the location, while the length byte it returns can itself be rewritten by the same transfer. The stimulus sweeps every start index from 0 to 10 against every byte count from 0 to 4. It follows each start index with a ten-byte read that wraps the bank. A host model tracks the expected contents, including the changing length byte.

// File: rtl/smb_cfg_pkg.sv
`timescale 1ns/1ps
package smb_cfg_pkg;
    localparam int NUM_OUT     = 9;
    localparam int FIELD_REGS  = (NUM_OUT + 7) / 8;
    localparam int EN_BASE     = 0;
    localparam int SLEW_BASE   = EN_BASE + FIELD_REGS;
    localparam int AMP_BASE    = SLEW_BASE + FIELD_REGS;
    localparam int ID_IDX      = AMP_BASE + FIELD_REGS;
    localparam int SPARE_IDX   = ID_IDX + 1;
    localparam int COUNT_IDX   = SPARE_IDX + 1;
    localparam int NUM_REGS    = COUNT_IDX + 1;
    localparam int LAST_IDX    = COUNT_IDX;
    localparam int SYNC_STAGES = 2;
    localparam logic [7:0] DEV_ID    = 8'h5A;
    localparam logic [6:0] ADDR_BASE = 7'h68;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA, ST_TX, ST_IGNORE
    } smb_state_e;

    function automatic logic [7:0] field_bits(int i, int base);
        logic [7:0] m;
        m = '0;
        for (int j = 0; j < 8; j++)
            if (i >= base && i < base + FIELD_REGS && (i - base) * 8 + j < NUM_OUT)
                m[j] = 1'b1;
        return m;
    endfunction

    function automatic logic [7:0] reg_mask(int i);
        return field_bits(i, EN_BASE) | field_bits(i, SLEW_BASE) |
               field_bits(i, AMP_BASE) | ((i == COUNT_IDX) ? 8'hFF : 8'h00);
    endfunction

    function automatic logic [7:0] reg_default(int i);
        return field_bits(i, EN_BASE) | field_bits(i, AMP_BASE) |
               ((i == ID_IDX) ? DEV_ID : 8'h00) |
               ((i == COUNT_IDX) ? 8'(NUM_REGS) : 8'h00);
    endfunction

    function automatic logic [6:0] sel_addr(logic [1:0] s);
        case (s)
            2'b01:   return ADDR_BASE + 7'd2;
            2'b10:   return ADDR_BASE + 7'd4;
            default: return ADDR_BASE;
        endcase
    endfunction

    function automatic logic [7:0] next_idx(logic [7:0] i);
        return (i >= 8'(LAST_IDX)) ? 8'h00 : i + 8'd1;
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync
    import smb_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_ff;
        logic [SYNC_STAGES-1:0] sda_ff;
        logic                   scl_p;
        logic                   sda_p;
    } sync_t;

    sync_t q, d;

    assign scl_s = q.scl_ff[SYNC_STAGES-1];
    assign sda_s = q.sda_ff[SYNC_STAGES-1];

    always_comb begin
        d        = q;
        d.scl_ff = {q.scl_ff[SYNC_STAGES-2:0], scl_in};
        d.sda_ff = {q.sda_ff[SYNC_STAGES-2:0], sda_in};
        d.scl_p  = scl_s;
        d.sda_p  = sda_s;
    end

    assign scl_rise  = scl_s & ~q.scl_p;
    assign scl_fall  = ~scl_s & q.scl_p;
    assign start_det = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_det  = scl_s & q.scl_p & ~q.sda_p & sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end
endmodule

// File: rtl/smb_reg_bank.sv
`timescale 1ns/1ps
module smb_reg_bank
    import smb_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         rd_idx,
    output logic [7:0]         rd_data,
    output logic [NUM_OUT-1:0] out_en,
    output logic [NUM_OUT-1:0] slew_sel,
    output logic [NUM_OUT-1:0] amp_sel,
    output logic [7:0]         count_val
);
    logic [NUM_REGS-1:0][7:0] regs_q, regs_d;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en && wr_idx == 8'(i))
                regs_d[i] = (regs_q[i] & ~reg_mask(i)) | (wr_data & reg_mask(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(i);
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == 8'(i)) rd_data = regs_q[i];
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        assign out_en[k]   = regs_q[EN_BASE + k / 8][k % 8];
        assign slew_sel[k] = regs_q[SLEW_BASE + k / 8][k % 8];
        assign amp_sel[k]  = regs_q[AMP_BASE + k / 8][k % 8];
    end

    assign count_val = regs_q[COUNT_IDX];
endmodule

// File: rtl/smb_cfg_target.sv
`timescale 1ns/1ps
module smb_cfg_target
    import smb_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [1:0]         addr_sel,
    output logic               sda_drive_low,
    output logic [NUM_OUT-1:0] out_en,
    output logic [NUM_OUT-1:0] slew_sel,
    output logic [NUM_OUT-1:0] amp_sel
);
    typedef struct packed {
        smb_state_e st;
        logic [3:0] bitcnt;
        logic       ack;
        logic [7:0] sh;
        logic [7:0] tx;
        logic       rw;
        logic       nack;
        logic [7:0] idx;
        logic [7:0] remain;
        logic       sda_low;
        logic       latched;
        logic [6:0] addr;
    } fsm_t;

    fsm_t q, d;

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en;
    logic [7:0] wr_idx, wr_data, rd_data, count_val;
    smb_state_e cur_st;
    logic       addr_latched;
    logic [6:0] dev_addr;

    smb_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (q.idx),
        .rd_data   (rd_data),
        .out_en    (out_en),
        .slew_sel  (slew_sel),
        .amp_sel   (amp_sel),
        .count_val (count_val)
    );

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_idx  = q.idx;
        wr_data = q.sh;

        if (!q.latched) begin
            d.latched = 1'b1;
            d.addr    = sel_addr(addr_sel);
        end

        if (stop_det) begin
            d.st = ST_IDLE; d.sda_low = 1'b0; d.ack = 1'b0; d.bitcnt = '0;
        end else if (start_det) begin
            d.st = ST_ADDR; d.sda_low = 1'b0; d.ack = 1'b0; d.bitcnt = '0;
        end else if (scl_rise) begin
            case (q.st)
                ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                    if (!q.ack && q.bitcnt < 4'd8) begin
                        d.sh     = {q.sh[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end
                end
                ST_TX: begin
                    if (q.ack)                   d.nack   = sda_s;
                    else if (q.bitcnt < 4'd8)    d.bitcnt = q.bitcnt + 4'd1;
                end
                default: ;
            endcase
        end else if (scl_fall) begin
            case (q.st)
                ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                    if (!q.ack && q.bitcnt == 4'd8) begin
                        d.ack     = 1'b1;
                        d.sda_low = 1'b1;
                        case (q.st)
                            ST_ADDR: begin
                                if (q.sh[7:1] == q.addr) begin
                                    d.rw = q.sh[0];
                                end else begin
                                    d.st = ST_IGNORE; d.ack = 1'b0; d.sda_low = 1'b0;
                                end
                            end
                            ST_INDEX: d.idx    = q.sh;
                            ST_COUNT: d.remain = q.sh;
                            default: begin
                                if (q.remain != 8'd0) begin
                                    wr_en    = 1'b1;
                                    d.idx    = next_idx(q.idx);
                                    d.remain = q.remain - 8'd1;
                                end
                            end
                        endcase
                    end else if (q.ack) begin
                        d.ack     = 1'b0;
                        d.bitcnt  = '0;
                        d.sda_low = 1'b0;
                        case (q.st)
                            ST_ADDR: begin
                                if (q.rw) begin
                                    d.st      = ST_TX;
                                    d.tx      = count_val;
                                    d.sda_low = ~count_val[7];
                                end else begin
                                    d.st = ST_INDEX;
                                end
                            end
                            ST_INDEX: d.st = ST_COUNT;
                            default:  d.st = ST_WDATA;
                        endcase
                    end
                end
                ST_TX: begin
                    if (q.ack) begin
                        d.ack    = 1'b0;
                        d.bitcnt = '0;
                        if (q.nack) begin
                            d.st      = ST_IGNORE;
                            d.sda_low = 1'b0;
                        end else begin
                            d.tx      = rd_data;
                            d.sda_low = ~rd_data[7];
                            d.idx     = next_idx(q.idx);
                        end
                    end else if (q.bitcnt == 4'd8) begin
                        d.ack     = 1'b1;
                        d.sda_low = 1'b0;
                    end else if (q.bitcnt != 4'd0) begin
                        d.tx      = {q.tx[6:0], 1'b0};
                        d.sda_low = ~q.tx[6];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.addr    <= ADDR_BASE;
        end else begin
            q <= d;
        end
    end

    assign sda_drive_low = q.sda_low;
    assign cur_st        = q.st;
    assign addr_latched  = q.latched;
    assign dev_addr      = q.addr;
endmodule

// File: rtl/smb_cfg_checker.sv
`timescale 1ns/1ps
module smb_cfg_checker
    import smb_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input smb_state_e cur_st,
    input logic       sda_low,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       addr_latched,
    input logic [6:0] dev_addr,
    input logic       wr_en,
    input logic [7:0] wr_idx,
    input logic [7:0] count_val
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        cur_st == ST_IDLE |-> !sda_low); // R10
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> cur_st == ST_IDLE); // R10
    AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        cur_st == ST_IGNORE |-> !sda_low); // R3
    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_low)); // R11
    AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cur_st == ST_WDATA); // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == 8'(COUNT_IDX)) |=> $stable(count_val)); // R9
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latched |=> (addr_latched && $stable(dev_addr))); // R2
endmodule

bind smb_cfg_target smb_cfg_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_st       (cur_st),
    .sda_low      (sda_drive_low),
    .scl_s        (scl_s),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .addr_latched (addr_latched),
    .dev_addr     (dev_addr),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .count_val    (count_val)
);

// File: tb/smb_cfg_target_tb.sv
`timescale 1ns/1ps
module smb_cfg_target_tb_top;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_scl = 1'b1;
    logic       host_sda = 1'b1;
    logic [1:0] addr_sel = 2'b00;
    logic       sda_drive_low;
    logic [8:0] out_en, slew_sel, amp_sel;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [9];
    logic [7:0] wbuf [8];

    always #5 clk = ~clk;
    assign sda_bus = host_sda & ~sda_drive_low;

    smb_cfg_target dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (host_scl),
        .sda_in        (sda_bus),
        .addr_sel      (addr_sel),
        .sda_drive_low (sda_drive_low),
        .out_en        (out_en),
        .slew_sel      (slew_sel),
        .amp_sel       (amp_sel)
    );

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wmask(input logic [7:0] i);
        if (i == 0 || i == 2 || i == 4 || i == 8) return 8'hFF;
        if (i == 1 || i == 3 || i == 5) return 8'h01;
        return 8'h00;
    endfunction

    function automatic logic [7:0] rd_model(input logic [7:0] i);
        return (i <= 8) ? mdl[i[3:0]] : 8'h00;
    endfunction

    function automatic logic [7:0] adv(input logic [7:0] i);
        return (i >= 8) ? 8'h00 : i + 8'd1;
    endfunction

    task automatic model_reset();
        mdl[0] = 8'hFF; mdl[1] = 8'h01; mdl[2] = 8'h00; mdl[3] = 8'h00;
        mdl[4] = 8'hFF; mdl[5] = 8'h01; mdl[6] = 8'h5A; mdl[7] = 8'h00;
        mdl[8] = 8'h09;
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] sel);
        host_scl = 1'b1; host_sda = 1'b1;
        rst_n = 1'b0; addr_sel = sel;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        addr_sel = sel + 2'd1; // R2: later select changes must be ignored
        model_reset();
    endtask

    task automatic bus_start();
        host_sda = 1'b1; wq(); host_scl = 1'b1; wq();
        host_sda = 1'b0; wq(); host_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wq(); host_scl = 1'b1; wq(); host_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        host_sda = b; wq(); host_scl = 1'b1; wq(); wq(); host_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        logic first, last;
        host_sda = 1'b1; wq(); host_scl = 1'b1;
        repeat (2) @(negedge clk); first = sda_bus;
        repeat (Q - 2) @(negedge clk); b = sda_bus;
        repeat (Q - 1) @(negedge clk); last = sda_bus;
        chk(first == last, "R11 sda moved while scl high", {15'd0, last}, {15'd0, first});
        host_scl = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
        send_bit(~give_ack);
    endtask

    task automatic chk_outs(input string tag);
        chk(out_en == {mdl[1][0], mdl[0]}, {tag, " out_en"}, {7'd0, out_en}, {7'd0, mdl[1][0], mdl[0]});
        chk(slew_sel == {mdl[3][0], mdl[2]}, {tag, " slew_sel"}, {7'd0, slew_sel}, {7'd0, mdl[3][0], mdl[2]});
        chk(amp_sel == {mdl[5][0], mdl[4]}, {tag, " amp_sel"}, {7'd0, amp_sel}, {7'd0, mdl[5][0], mdl[4]});
    endtask

    task automatic blk_write(input logic [6:0] a, input logic [7:0] n, input logic [7:0] x,
                             input int nb, input string tag);
        logic ack;
        logic [7:0] idx;
        bus_start();
        write_byte({a, 1'b0}, ack); chk(ack, "R3 address ack", {15'd0, ack}, 16'd1);
        write_byte(n, ack);         chk(ack, "R4 index ack", {15'd0, ack}, 16'd1);
        write_byte(x, ack);         chk(ack, "R4 count ack", {15'd0, ack}, 16'd1);
        idx = n;
        for (int k = 0; k < nb; k++) begin
            write_byte(wbuf[k], ack);
            chk(ack, {tag, " data ack"}, {15'd0, ack}, 16'd1);
            if (k < int'(x)) begin
                if (idx <= 8) mdl[idx[3:0]] = (mdl[idx[3:0]] & ~wmask(idx)) | (wbuf[k] & wmask(idx));
                idx = adv(idx);
            end
        end
        bus_stop();
    endtask

    task automatic blk_read(input logic [6:0] a, input logic [7:0] n, input int len, input string tag);
        logic ack;
        logic [7:0] v, idx;
        bus_start();
        write_byte({a, 1'b0}, ack); chk(ack, "R3 address ack", {15'd0, ack}, 16'd1);
        write_byte(n, ack);         chk(ack, "R7 index ack", {15'd0, ack}, 16'd1);
        bus_start();
        write_byte({a, 1'b1}, ack); chk(ack, "R7 read address ack", {15'd0, ack}, 16'd1);
        read_byte(v, 1'b1);
        chk(v == mdl[8], {tag, " length byte"}, {8'd0, v}, {8'd0, mdl[8]});
        idx = n;
        for (int k = 0; k < len; k++) begin
            read_byte(v, k != len - 1);
            chk(v == rd_model(idx), {tag, " read data"}, {idx, v}, {idx, rd_model(idx)});
            idx = adv(idx);
        end
        read_byte(v, 1'b0);
        chk(v == 8'hFF, "R7 released after NACK", {8'd0, v}, 16'h00FF);
        bus_stop();
    endtask

    task automatic probe_wrong(input logic [6:0] a);
        logic ack;
        bus_start();
        write_byte({a, 1'b0}, ack); chk(!ack, "R3 mismatch address", {15'd0, ack}, 16'd0);
        write_byte(8'h00, ack);     chk(!ack, "R3 ignored byte", {15'd0, ack}, 16'd0);
        write_byte(8'h01, ack);     chk(!ack, "R3 ignored byte", {15'd0, ack}, 16'd0);
        write_byte(8'h00, ack);     chk(!ack, "R3 ignored byte", {15'd0, ack}, 16'd0);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        logic [6:0] exp_a, cand;

        // R1: reset values
        do_reset(2'b00);
        chk(out_en == 9'h1FF, "R1 out_en default", {7'd0, out_en}, 16'h01FF);
        chk(slew_sel == 9'h000, "R1 slew default", {7'd0, slew_sel}, 16'h0000);
        chk(amp_sel == 9'h1FF, "R1 amp default", {7'd0, amp_sel}, 16'h01FF);
        blk_read(7'h68, 8'd0, 9, "R1");

        // R2/R3: address select sweep
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            exp_a = (s == 1) ? 7'h6A : (s == 2) ? 7'h6C : 7'h68;
            for (int c = 0; c < 3; c++) begin
                cand = 7'h68 + 7'(2 * c);
                if (cand == exp_a) begin
                    bus_start();
                    write_byte({cand, 1'b1}, ack);
                    chk(ack, "R2 latched address ack (read bit)", {15'd0, ack}, 16'd1);
                    read_byte(v, 1'b0);
                    chk(v == 8'h09, "R7 length byte", {8'd0, v}, 16'h0009);
                    bus_stop();
                end else begin
                    probe_wrong(cand);
                end
            end
            chk_outs("R3 after mismatch");
        end

        // R4/R6: index and count sweep with wrapped reads
        do_reset(2'b00);
        for (int n = 0; n <= 10; n++) begin
            for (int x = 0; x <= 4; x++) begin
                for (int k = 0; k < 8; k++) wbuf[k] = 8'((n * 37 + x * 13 + k * 11 + 5) & 8'hFF);
                blk_write(7'h68, 8'(n), 8'(x), x, "R4");
                chk_outs("R4");
            end
            blk_read(7'h68, 8'(n), 10, "R6 wrap");
        end

        // R5: bytes past the count
        do_reset(2'b00);
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
        blk_write(7'h68, 8'd2, 8'd1, 3, "R5");
        chk_outs("R5");
        chk(slew_sel[7:0] == 8'hAA, "R5 first byte kept", {8'd0, slew_sel[7:0]}, 16'h00AA);

        // R8: read-only and unimplemented locations
        wbuf[0] = 8'h00; wbuf[1] = 8'h77;
        blk_write(7'h68, 8'd6, 8'd2, 2, "R8");
        blk_read(7'h68, 8'd6, 2, "R8");
        wbuf[0] = 8'h55;
        blk_write(7'h68, 8'd9, 8'd1, 1, "R8");
        blk_read(7'h68, 8'd9, 2, "R8");
        blk_read(7'h68, 8'd1, 1, "R8 reserved bits");

        // R9: programmable length byte
        wbuf[0] = 8'h03;
        blk_write(7'h68, 8'd8, 8'd1, 1, "R9");
        blk_read(7'h68, 8'd0, 3, "R9");

        // R10: STOP inside a data byte
        bus_start();
        write_byte({7'h68, 1'b0}, ack); chk(ack, "R10 address ack", {15'd0, ack}, 16'd1);
        write_byte(8'h00, ack);         chk(ack, "R10 index ack", {15'd0, ack}, 16'd1);
        write_byte(8'h01, ack);         chk(ack, "R10 count ack", {15'd0, ack}, 16'd1);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        repeat (4) @(negedge clk);
        chk(sda_drive_low == 1'b0, "R10 released after stop", {15'd0, sda_drive_low}, 16'd0);
        chk_outs("R10 partial byte dropped");
        wbuf[0] = 8'h0F;
        blk_write(7'h68, 8'd0, 8'd1, 1, "R10 next transfer");
        chk_outs("R10 next transfer");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule